// File: doc/BRIEF.md
# Fetch Thread Selector

This block picks, every cycle, which hardware thread a multithreaded fetch stage should serve. It looks at each thread's fetch status code, an active-thread mask and two per-thread occupancy counts, and presents a grant as a valid flag plus a thread index. The grant is combinational from the inputs and the internal state. The fetch stage consumes it by raising `fetch_accept` in the same cycle.

A two-bit policy input chooses the arbitration scheme. Code 0 is single-thread. Code 1 is round-robin over an internal priority list: the winner moves to the back of the list. Codes 2 and 3 are least-occupied selection, using the instruction-queue counts and the load/store-queue counts respectively. The policy input is expected to stay fixed between resets.

The grant side behaves as a valid/ready pair, with `grant_valid` as valid and `fetch_accept` as ready. A low `fetch_accept` is back-pressure. It leaves the round-robin state untouched, so the same grant stays on offer as long as the inputs do not change. A grant is never held or registered on behalf of the consumer. If inputs change while the grant is waiting, the offer follows them.

Top module: `fetch_thread_sel`

## Requirements
- R1: Status is a 3-bit code per thread. A thread is eligible only if its code is 0 (running), 1 (idle) or 6 (cache line ready). Codes 2, 3, 4, 5 and 7 make a thread ineligible.
- R2: Under policies 1, 2 and 3, a thread whose `active_mask` bit is low is never granted.
- R3: After reset the priority list holds threads in index order 0 to N-1. Round-robin with every thread eligible therefore grants thread 0 first.
- R4: With more than one thread configured, policy 0 always gives `grant_valid` high and `grant_tid` 0, whatever the status and mask inputs.
- R5: Under policy 1, the grant goes to the first eligible thread found from the head of the priority list. On an accepted grant that thread moves to the tail, and the other threads keep their relative order.
- R6: Under policies 1, 2 and 3, `grant_valid` is low when no thread is eligible and high when at least one is.
- R7: The priority list changes only at a clock edge where `grant_valid` and `fetch_accept` are both high. In any other cycle with unchanged inputs, the grant is unchanged.
- R8: Policy 2 grants the eligible thread with the smallest `iq_occ` count. Policy 3 does the same using `lsq_occ`. The count vector that is not selected has no effect on the grant.
- R9: Under policies 2 and 3, equal smallest counts resolve to the lower thread index.
- R10: With one thread configured, thread 0 is granted under every policy exactly when it is eligible. Otherwise `grant_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | 0 single, 1 round-robin, 2 IQ occupancy, 3 LSQ occupancy |
| active_mask | input | NTHR | One bit per thread that is currently active |
| thr_status | input | 3*NTHR | Per-thread status codes, thread i at bits [3i+2:3i] |
| iq_occ | input | OCC_W*NTHR | Per-thread instruction-queue counts |
| lsq_occ | input | OCC_W*NTHR | Per-thread load/store-queue counts |
| fetch_accept | input | 1 | The consumer takes the current grant this cycle |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TID_W | Index of the granted thread |

## Verification
The assertions check on every cycle that:
- a valid grant always names an active, eligible thread;
- validity tracks whether any thread is eligible;
- the single-thread policy pins thread 0;
- the occupancy grant is a lowest count with the lowest index;
- a thread just accepted in round-robin yields whenever another thread is eligible;
- the grant stays put when nothing was accepted and no input moved.

Only the directed scenarios can show the exact order of the priority list. One example is a thread that was skipped while blocked and is then found ahead of the others. The scenarios also cover the reset ordering and the one-thread configuration.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_IDLE       = 3'd1,
    ST_SQUASH     = 3'd2,
    ST_BLOCKED    = 3'd3,
    ST_WAIT_RESP  = 3'd4,
    ST_WAIT_RETRY = 3'd5,
    ST_LINE_READY = 3'd6,
    ST_QUIESCE    = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_RR     = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } fetch_pol_e;

  localparam int unsigned ST_W = 3;

  function automatic logic state_can_fetch(input logic [ST_W-1:0] code);
    return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_LINE_READY);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig
  import fts_pkg::*;
#(
  parameter int unsigned NTHR = 4
) (
  input  logic [NTHR-1:0]      active_mask,
  input  logic [NTHR*ST_W-1:0] thr_status,
  output logic [NTHR-1:0]      elig
);

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    assign elig[g] = active_mask[g] && state_can_fetch(thr_status[g*ST_W +: ST_W]);
  end

endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  elig,
  input  logic             adv,
  output logic             pick_valid,
  output logic [TID_W-1:0] pick_tid
);

  logic [TID_W-1:0] order_q [NTHR];
  logic [TID_W-1:0] order_d [NTHR];
  logic [TID_W-1:0] shifted [NTHR];
  logic [TID_W-1:0] pos;

  // scan from the head of the list
  always_comb begin
    pick_valid = 1'b0;
    pos        = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (!pick_valid && elig[order_q[i]]) begin
        pick_valid = 1'b1;
        pos        = TID_W'(i);
      end
    end
    pick_tid = order_q[pos];
  end

  // entries behind the winner slide forward, winner lands at the tail
  for (genvar g = 0; g < NTHR - 1; g++) begin : g_shift
    assign shifted[g] = order_q[g+1];
  end
  assign shifted[NTHR-1] = order_q[pos];

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      order_d[i] = (i < int'(pos)) ? order_q[i] : shifted[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) order_q[i] <= TID_W'(i);
    end else if (adv) begin
      order_q <= order_d;
    end
  end

endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned TID_W = 2,
  parameter int unsigned OCC_W = 6
) (
  input  logic [NTHR-1:0]       elig,
  input  logic [NTHR*OCC_W-1:0] occ,
  output logic                  pick_valid,
  output logic [TID_W-1:0]      pick_tid
);

  logic [OCC_W-1:0] best;

  always_comb begin
    pick_valid = 1'b0;
    pick_tid   = '0;
    best       = '0;
    for (int i = 0; i < NTHR; i++) begin
      // strict less-than keeps the lower index on a tie
      if (elig[i] && (!pick_valid || occ[i*OCC_W +: OCC_W] < best)) begin
        pick_valid = 1'b1;
        pick_tid   = TID_W'(i);
        best       = occ[i*OCC_W +: OCC_W];
      end
    end
  end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned OCC_W = 6,
  localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            policy_sel,
  input  logic [NTHR-1:0]       active_mask,
  input  logic [NTHR*ST_W-1:0]  thr_status,
  input  logic [NTHR*OCC_W-1:0] iq_occ,
  input  logic [NTHR*OCC_W-1:0] lsq_occ,
  input  logic                  fetch_accept,
  output logic                  grant_valid,
  output logic [TID_W-1:0]      grant_tid
);

  fetch_pol_e      pol;
  logic [NTHR-1:0] elig;

  assign pol = fetch_pol_e'(policy_sel);

  fts_elig #(.NTHR(NTHR)) u_elig (
    .active_mask (active_mask),
    .thr_status  (thr_status),
    .elig        (elig)
  );

  if (NTHR == 1) begin : g_one
    assign grant_valid = elig[0];
    assign grant_tid   = '0;
  end else begin : g_multi
    logic                  rr_valid, occ_valid, rr_adv;
    logic [TID_W-1:0]      rr_tid, occ_tid;
    logic [NTHR*OCC_W-1:0] occ_sel;

    assign occ_sel = (pol == POL_LSQ) ? lsq_occ : iq_occ;
    assign rr_adv  = (pol == POL_RR) && rr_valid && fetch_accept;

    fts_rr_list #(.NTHR(NTHR), .TID_W(TID_W)) u_rr (
      .clk        (clk),
      .rst_n      (rst_n),
      .elig       (elig),
      .adv        (rr_adv),
      .pick_valid (rr_valid),
      .pick_tid   (rr_tid)
    );

    fts_min_pick #(.NTHR(NTHR), .TID_W(TID_W), .OCC_W(OCC_W)) u_min (
      .elig       (elig),
      .occ        (occ_sel),
      .pick_valid (occ_valid),
      .pick_tid   (occ_tid)
    );

    always_comb begin
      unique case (pol)
        POL_SINGLE: begin grant_valid = 1'b1;      grant_tid = '0;      end
        POL_RR:     begin grant_valid = rr_valid;  grant_tid = rr_tid;  end
        default:    begin grant_valid = occ_valid; grant_tid = occ_tid; end
      endcase
    end
  end

endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned OCC_W = 6,
  parameter int unsigned TID_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            policy_sel,
  input logic [NTHR-1:0]       active_mask,
  input logic [NTHR*3-1:0]     thr_status,
  input logic [NTHR*OCC_W-1:0] iq_occ,
  input logic [NTHR*OCC_W-1:0] lsq_occ,
  input logic                  fetch_accept,
  input logic                  grant_valid,
  input logic [TID_W-1:0]      grant_tid
);

  localparam int unsigned NSLOT = 1 << TID_W;

  logic [NSLOT-1:0] ok;
  logic [OCC_W-1:0] cnt [NSLOT];
  logic             any_ok, occ_mode, rr_mode;
  logic             smaller_seen, tie_lower_seen, others_ok;
  logic             prev_acc;
  logic [TID_W-1:0] prev_tid;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NTHR) begin : g_real
      logic [2:0] c;
      assign c      = thr_status[g*3 +: 3];
      assign ok[g]  = active_mask[g] && (c == 3'd0 || c == 3'd1 || c == 3'd6);
      assign cnt[g] = policy_sel[0] ? lsq_occ[g*OCC_W +: OCC_W] : iq_occ[g*OCC_W +: OCC_W];
    end else begin : g_pad
      assign ok[g]  = 1'b0;
      assign cnt[g] = '0;
    end
  end

  assign any_ok   = |ok;
  assign occ_mode = policy_sel[1];
  assign rr_mode  = (policy_sel == 2'd1);

  always_comb begin
    smaller_seen   = 1'b0;
    tie_lower_seen = 1'b0;
    others_ok      = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (ok[i] && cnt[i] < cnt[grant_tid]) smaller_seen = 1'b1;
      if (ok[i] && cnt[i] == cnt[grant_tid] && i < int'(grant_tid)) tie_lower_seen = 1'b1;
      if (ok[i] && i != int'(prev_tid)) others_ok = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_acc <= 1'b0;
      prev_tid <= '0;
    end else begin
      prev_acc <= rr_mode && grant_valid && fetch_accept;
      prev_tid <= grant_tid;
    end
  end

  // R1 and R2
  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && policy_sel != 2'd0) |-> ok[grant_tid]);

  // R6
  a_r6_none_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel != 2'd0 && !any_ok) |-> !grant_valid);

  a_r6_some_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel != 2'd0 && any_ok) |-> grant_valid);

  if (NTHR > 1) begin : g_single
    // R4
    a_r4_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == 2'd0) |-> (grant_valid && grant_tid == '0));
  end else begin : g_one
    // R10
    a_r10_one_thread: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == ok[0]);
  end

  // R8
  a_r8_min_count: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_mode && grant_valid) |-> !smaller_seen);

  // R9
  a_r9_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_mode && grant_valid) |-> !tie_lower_seen);

  // R5
  a_r5_winner_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_mode && prev_acc && others_ok) |-> (grant_tid != prev_tid));

  // R7
  a_r7_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(grant_valid && fetch_accept) && $stable(policy_sel) && $stable(active_mask)
     && $stable(thr_status) && $stable(iq_occ) && $stable(lsq_occ))
    |-> ($stable(grant_valid) && $stable(grant_tid)));

endmodule

bind fetch_thread_sel fts_checker #(.NTHR(NTHR), .OCC_W(OCC_W), .TID_W(TID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .policy_sel   (policy_sel),
  .active_mask  (active_mask),
  .thr_status   (thr_status),
  .iq_occ       (iq_occ),
  .lsq_occ      (lsq_occ),
  .fetch_accept (fetch_accept),
  .grant_valid  (grant_valid),
  .grant_tid    (grant_tid)
);

// File: tb/fetch_thread_sel_tb.sv
`timescale 1ns/1ps
module fetch_thread_sel_tb;

  localparam int N = 4;
  localparam int W = 6;
  localparam logic [2:0] RUN = 3'd0, IDLE = 3'd1, BLK = 3'd3, READY = 3'd6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pol = 2'd1;
  logic [N-1:0]  act = '1;
  logic [3*N-1:0] st = '0;
  logic [W*N-1:0] iq = '0, lsq = '0;
  logic          acc = 1'b0;
  logic          gv;
  logic [1:0]    gt;
  logic          act1 = 1'b1;
  logic [2:0]    st1 = RUN;
  logic [W-1:0]  iq1 = '0, lsq1 = '0;
  logic          gv1;
  logic [0:0]    gt1;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  fetch_thread_sel #(.NTHR(N), .OCC_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .active_mask(act), .thr_status(st),
    .iq_occ(iq), .lsq_occ(lsq), .fetch_accept(acc), .grant_valid(gv), .grant_tid(gt));

  fetch_thread_sel #(.NTHR(1), .OCC_W(W)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .active_mask(act1), .thr_status(st1),
    .iq_occ(iq1), .lsq_occ(lsq1), .fetch_accept(acc), .grant_valid(gv1), .grant_tid(gt1));

  task automatic chk(input string tag, input logic v, input int t,
                     input logic ev, input int et);
    vectors++;
    if (v !== ev || (ev && t != et)) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d", tag, v, t, ev, et);
    end
  endtask

  task automatic all_st(input logic [2:0] c);
    for (int i = 0; i < N; i++) st[i*3 +: 3] = c;
  endtask

  task automatic set_cnt(input int a, input int b, input int c, input int d, input bit to_lsq);
    logic [W*N-1:0] v;
    v = {W'(d), W'(c), W'(b), W'(a)};
    if (to_lsq) lsq = v; else iq = v;
  endtask

  task automatic do_reset(input logic [1:0] p);
    @(negedge clk);
    rst_n = 1'b0; pol = p; acc = 1'b0; act = '1; all_st(RUN);
    iq = '0; lsq = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // check the offer, then accept it across one edge
  task automatic take(input string tag, input int et);
    #1 chk(tag, gv, int'(gt), 1'b1, et);
    acc = 1'b1;
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(2'd1);
    #1 chk("R3 reset head is thread 0", gv, int'(gt), 1'b1, 0);
  endtask

  task automatic t_single;
    do_reset(2'd0);
    all_st(BLK);
    #1 chk("R4 single with all blocked", gv, int'(gt), 1'b1, 0);
    act = '0;
    #1 chk("R4 single with empty mask", gv, int'(gt), 1'b1, 0);
  endtask

  task automatic t_elig;
    do_reset(2'd1);
    for (int c = 0; c < 8; c++) begin
      all_st(BLK);
      st[2*3 +: 3] = 3'(c);
      #1 chk($sformatf("R1 status code %0d", c), gv, int'(gt),
             (c == 0 || c == 1 || c == 6), 2);
    end
    all_st(BLK); st[2*3 +: 3] = RUN; act[2] = 1'b0;
    #1 chk("R2 inactive running thread", gv, int'(gt), 1'b0, 0);
    act = '1; st[1*3 +: 3] = READY; act[1] = 1'b0;
    #1 chk("R2 masked thread skipped", gv, int'(gt), 1'b1, 2);
  endtask

  task automatic t_none;
    do_reset(2'd1);
    all_st(BLK);
    #1 chk("R6 none eligible round-robin", gv, int'(gt), 1'b0, 0);
    do_reset(2'd2);
    all_st(3'd4);
    #1 chk("R6 none eligible occupancy", gv, int'(gt), 1'b0, 0);
    st[3*3 +: 3] = IDLE;
    #1 chk("R6 one eligible occupancy", gv, int'(gt), 1'b1, 3);
  endtask

  task automatic t_rr;
    do_reset(2'd1);
    take("R5 rotation step 0", 0);
    take("R5 rotation step 1", 1);
    take("R5 rotation step 2", 2);
    take("R5 rotation step 3", 3);
    #1 chk("R5 rotation wraps", gv, int'(gt), 1'b1, 0);
    repeat (3) @(negedge clk);
    #1 chk("R7 no accept keeps grant", gv, int'(gt), 1'b1, 0);
    // skipped thread stays near the head
    do_reset(2'd1);
    st[2*3 +: 3] = BLK;
    take("R5 skip run 0", 0);
    take("R5 skip run 1", 1);
    take("R5 skip run 3", 3);
    all_st(BLK);
    acc = 1'b1;
    @(negedge clk);
    acc = 1'b0;
    all_st(RUN);
    #1 chk("R5 R7 skipped thread now at head", gv, int'(gt), 1'b1, 2);
    take("R5 accept head", 2);
    #1 chk("R5 order after move to tail", gv, int'(gt), 1'b1, 0);
  endtask

  task automatic t_occ;
    do_reset(2'd2);
    set_cnt(5, 3, 7, 3, 1'b0);
    set_cnt(9, 9, 0, 9, 1'b1);
    #1 chk("R9 IQ tie picks lower index", gv, int'(gt), 1'b1, 1);
    chk("R8 LSQ counts ignored in IQ mode", gv, int'(gt), 1'b1, 1);
    st[1*3 +: 3] = BLK;
    #1 chk("R8 ineligible minimum skipped", gv, int'(gt), 1'b1, 3);
    set_cnt(2, 3, 7, 3, 1'b0);
    #1 chk("R8 new minimum thread 0", gv, int'(gt), 1'b1, 0);
    do_reset(2'd3);
    set_cnt(0, 0, 5, 0, 1'b0);
    set_cnt(9, 9, 0, 9, 1'b1);
    #1 chk("R8 LSQ minimum", gv, int'(gt), 1'b1, 2);
    set_cnt(4, 4, 4, 4, 1'b1);
    #1 chk("R9 LSQ all equal", gv, int'(gt), 1'b1, 0);
  endtask

  task automatic t_one;
    do_reset(2'd1);
    act1 = 1'b1; st1 = RUN;
    #1 chk("R10 one thread eligible", gv1, int'(gt1), 1'b1, 0);
    st1 = BLK;
    #1 chk("R10 one thread blocked", gv1, int'(gt1), 1'b0, 0);
    do_reset(2'd0);
    st1 = BLK;
    #1 chk("R10 single policy blocked", gv1, int'(gt1), 1'b0, 0);
    st1 = READY; act1 = 1'b0;
    #1 chk("R10 inactive thread", gv1, int'(gt1), 1'b0, 0);
    act1 = 1'b1;
    #1 chk("R10 single policy ready", gv1, int'(gt1), 1'b1, 0);
  endtask

  initial begin
    t_reset_state();
    t_single();
    t_elig();
    t_none();
    t_rr();
    t_occ();
    t_one();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: got running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule